// File: doc/BRIEF.md
# Phase Imbalance Integrating Monitor

This block watches a three-phase supply for imbalance and lock disturbance, sample by sample, in signed fixed point. On every sample strobe it takes a phase-tracking error, the direct-axis line voltage, the line magnitude and the elapsed time step. It forms an imbalance metric from the square of the tracking error plus the square of the voltage-to-magnitude gap, smooths it with a first-order low-pass filter, subtracts a programmable reference and integrates the excess, weighted by the time step, into an accumulator bounded above and below.

When the accumulator reaches its upper bound, or when an external line-loss flag is raised, the transient alarm is active. An alarm that persists over a programmable number of consecutive sample strobes sets a trip. The trip stays latched until a fault-reset pulse arrives while the alarm is quiet. Only the alarm, the trip and the accumulator value leave the block.

Top module: `phase_imbalance_monitor`

## Requirements
- R1: On each strobe the metric is sat(pllErr² + (lineVx − lineMag)²), with saturation to the signed 32-bit range, and the filter state y becomes sat(y + ((metric − y) >>> filtShift)).
- R2: On each strobe the integrator adds sat(((yNew − imbRef) × dtStep) >>> DT_FRAC), so a positive excess raises it and a negative excess lowers it; dtStep is unsigned with DT_FRAC fraction bits.
- R3: The integrator never rises above intLimit: a sum beyond it is replaced by intLimit.
- R4: The integrator never falls below intFloor: a sum beneath it is replaced by intFloor.
- R5: Filter state and integrator change only on a clock where sampleValid is 1.
- R6: alarm is 1 whenever the registered integrator is greater than or equal to intLimit (signed compare).
- R7: lineLoss at 1 makes alarm 1 in the same cycle, whatever the integrator holds.
- R8: A persistence count advances on each strobe seen with alarm high and clears on any clock with alarm low; trip sets at the strobe whose count reaches tripDelay consecutive alarmed strobes.
- R9: trip stays 1 once set; faultReset is ignored while alarm is 1 and clears trip on a clock where alarm is 0.
- R10: After reset the integrator and filter are 0 and trip is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Sample strobe, one clock per sample |
| pllErr | input | IN_W | Signed phase-tracking error |
| lineVx | input | IN_W | Signed direct-axis line voltage |
| lineMag | input | IN_W | Signed line magnitude |
| dtStep | input | IN_W | Unsigned time step, DT_FRAC fraction bits |
| imbRef | input | DATA_W | Signed imbalance reference |
| intLimit | input | DATA_W | Signed integrator ceiling and alarm level |
| intFloor | input | DATA_W | Signed integrator floor |
| filtShift | input | SHIFT_W | Filter shift k |
| tripDelay | input | TIMER_W | Alarmed strobes needed for a trip |
| lineLoss | input | 1 | External line-loss flag |
| faultReset | input | 1 | Trip clear request |
| alarm | output | 1 | Transient alarm |
| trip | output | 1 | Latched trip |
| integ | output | DATA_W | Signed integrator value |

## Verification
The bench builds the block with DT_FRAC at 4 and TIMER_W at 8, so a time step of 16 weighs the excess by exactly one and persistence windows of a few strobes are reached in a handful of cycles. With a 16-bit voltage gap of full span the squared metric exceeds the 32-bit range, so the sum saturation and the upper clamp are both exercised. A small ceiling and floor make the clamp values exact literals, and a short tripDelay lets an interrupted alarm sequence show the count clearing.

// File: rtl/pim_pkg.sv
package pim_pkg;

  // Strobes issued by the control towards the datapath.
  typedef struct packed {
    logic update;
  } pimStrobe_t;

  // Status returned by the datapath.
  typedef struct packed {
    logic atLimit;
  } pimStatus_t;

endpackage

// File: rtl/pim_datapath.sv
module pim_datapath
  import pim_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IN_W    = 16,
  parameter int DT_FRAC = 8,
  parameter int SHIFT_W = $clog2(DATA_W)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pimStrobe_t               strobe,
  input  logic signed [IN_W-1:0]   pllErr,
  input  logic signed [IN_W-1:0]   lineVx,
  input  logic signed [IN_W-1:0]   lineMag,
  input  logic        [IN_W-1:0]   dtStep,
  input  logic signed [DATA_W-1:0] imbRef,
  input  logic signed [DATA_W-1:0] intLimit,
  input  logic signed [DATA_W-1:0] intFloor,
  input  logic        [SHIFT_W-1:0] filtShift,
  output logic signed [DATA_W-1:0] integ,
  output pimStatus_t               status
);

  localparam int ACC_W = 2 * DATA_W;
  localparam logic signed [ACC_W-1:0] MAX_V =
    signed'((ACC_W'(1) << (DATA_W - 1)) - ACC_W'(1));
  localparam logic signed [ACC_W-1:0] MIN_V = ~MAX_V;

  function automatic logic signed [DATA_W-1:0] satW(input logic signed [ACC_W-1:0] v);
    if (v > MAX_V)      return MAX_V[DATA_W-1:0];
    else if (v < MIN_V) return MIN_V[DATA_W-1:0];
    else                return v[DATA_W-1:0];
  endfunction

  logic signed [DATA_W-1:0] filt;
  logic signed [DATA_W-1:0] metric, filtNext, excess, incr, integNext;
  logic signed [ACC_W-1:0]  errW, gapW, filtW, incrWide, intSum;

  always_comb begin
    errW     = ACC_W'(pllErr);
    gapW     = ACC_W'(lineVx) - ACC_W'(lineMag);
    metric   = satW(errW * errW + gapW * gapW);
    filtW    = ACC_W'(filt);
    filtNext = satW(filtW + ((ACC_W'(metric) - filtW) >>> filtShift));
    excess   = satW(ACC_W'(filtNext) - ACC_W'(imbRef));
    incrWide = (ACC_W'(excess) * signed'(ACC_W'(dtStep))) >>> DT_FRAC;
    incr     = satW(incrWide);
    intSum   = ACC_W'(integ) + ACC_W'(incr);
    if (intSum > ACC_W'(intLimit))      integNext = intLimit;
    else if (intSum < ACC_W'(intFloor)) integNext = intFloor;
    else                                integNext = intSum[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filt  <= '0;
      integ <= '0;
    end else if (strobe.update) begin
      filt  <= filtNext;
      integ <= integNext;
    end
  end

  assign status.atLimit = (integ >= intLimit);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.update |=> $stable(integ)); // R5

  AST_INT_CEIL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.update && intFloor <= intLimit) |=> (integ <= $past(intLimit))); // R3

  AST_INT_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.update && intFloor <= intLimit) |=> (integ >= $past(intFloor))); // R4

endmodule

// File: rtl/pim_control.sv
module pim_control
  import pim_pkg::*;
#(
  parameter int TIMER_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic               lineLoss,
  input  logic               faultReset,
  input  logic [TIMER_W-1:0] tripDelay,
  input  pimStatus_t         status,
  output pimStrobe_t         strobe,
  output logic               alarm,
  output logic               trip
);

  logic [TIMER_W-1:0] persistCnt;
  logic [TIMER_W:0]   cntNext;

  assign alarm         = lineLoss | status.atLimit;
  assign strobe.update = sampleValid;
  assign cntNext       = {1'b0, persistCnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      persistCnt <= '0;
      trip       <= 1'b0;
    end else if (!alarm) begin
      persistCnt <= '0;
      if (faultReset) trip <= 1'b0;
    end else if (sampleValid) begin
      if (persistCnt != '1) persistCnt <= cntNext[TIMER_W-1:0];
      if (cntNext >= {1'b0, tripDelay}) trip <= 1'b1;
    end
  end

  AST_LOSS_ALARM: assert property (@(posedge clk) disable iff (!rstN)
    lineLoss |-> alarm); // R7

  AST_TRIP_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (trip && !(faultReset && !alarm)) |=> trip); // R9

  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !alarm |=> (persistCnt == '0)); // R8

  AST_TRIP_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trip) |-> ($past(alarm) && $past(sampleValid))); // R8

endmodule

// File: rtl/phase_imbalance_monitor.sv
module phase_imbalance_monitor
  import pim_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IN_W    = 16,
  parameter int DT_FRAC = 8,
  parameter int TIMER_W = 24,
  parameter int SHIFT_W = $clog2(DATA_W)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sampleValid,
  input  logic signed [IN_W-1:0]    pllErr,
  input  logic signed [IN_W-1:0]    lineVx,
  input  logic signed [IN_W-1:0]    lineMag,
  input  logic        [IN_W-1:0]    dtStep,
  input  logic signed [DATA_W-1:0]  imbRef,
  input  logic signed [DATA_W-1:0]  intLimit,
  input  logic signed [DATA_W-1:0]  intFloor,
  input  logic        [SHIFT_W-1:0] filtShift,
  input  logic        [TIMER_W-1:0] tripDelay,
  input  logic                      lineLoss,
  input  logic                      faultReset,
  output logic                      alarm,
  output logic                      trip,
  output logic signed [DATA_W-1:0]  integ
);

  pimStrobe_t strobe;
  pimStatus_t status;

  pim_control #(.TIMER_W(TIMER_W)) i_control (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .lineLoss(lineLoss),
    .faultReset(faultReset), .tripDelay(tripDelay), .status(status),
    .strobe(strobe), .alarm(alarm), .trip(trip)
  );

  pim_datapath #(.DATA_W(DATA_W), .IN_W(IN_W), .DT_FRAC(DT_FRAC), .SHIFT_W(SHIFT_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pllErr(pllErr), .lineVx(lineVx),
    .lineMag(lineMag), .dtStep(dtStep), .imbRef(imbRef), .intLimit(intLimit),
    .intFloor(intFloor), .filtShift(filtShift), .integ(integ), .status(status)
  );

  AST_RESET_TRIP: assert property (@(posedge clk)
    !rstN |=> (!trip && integ == '0)); // R10

endmodule

// File: tb/test_phase_imbalance_monitor.sv
module test_phase_imbalance_monitor;
  localparam int DATA_W = 32, IN_W = 16, DT_FRAC = 4, TIMER_W = 8, SHIFT_W = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, sampleValid, lineLoss, faultReset, alarm, trip;
  logic signed [IN_W-1:0] pllErr, lineVx, lineMag;
  logic [IN_W-1:0] dtStep;
  logic signed [DATA_W-1:0] imbRef, intLimit, intFloor, integ;
  logic [SHIFT_W-1:0] filtShift;
  logic [TIMER_W-1:0] tripDelay;

  phase_imbalance_monitor #(.DATA_W(DATA_W), .IN_W(IN_W), .DT_FRAC(DT_FRAC),
    .TIMER_W(TIMER_W), .SHIFT_W(SHIFT_W)) i_phase_imbalance_monitor (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .pllErr(pllErr),
    .lineVx(lineVx), .lineMag(lineMag), .dtStep(dtStep), .imbRef(imbRef),
    .intLimit(intLimit), .intFloor(intFloor), .filtShift(filtShift),
    .tripDelay(tripDelay), .lineLoss(lineLoss), .faultReset(faultReset),
    .alarm(alarm), .trip(trip), .integ(integ));

  int nCmp = 0, nBad = 0;
  bit done = 0;

  // Reference model state
  longint mFilt, mInt, sq, fN, ex, inc, sm, pe, gap;
  int mCnt;
  bit mTrip, mAl;

  function automatic longint sat32(longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mFilt = 0; mInt = 0; mCnt = 0; mTrip = 0;
    end else begin
      mAl = lineLoss || (mInt >= longint'(intLimit));
      if (!mAl) begin
        mCnt = 0;
        if (faultReset) mTrip = 0;
      end else if (sampleValid) begin
        if (mCnt + 1 >= int'(tripDelay)) mTrip = 1;
        if (mCnt < 255) mCnt++;
      end
      if (sampleValid) begin
        pe  = longint'(pllErr);
        gap = longint'(lineVx) - longint'(lineMag);
        sq  = sat32(pe * pe + gap * gap);
        fN  = sat32(mFilt + ((sq - mFilt) >>> filtShift));
        ex  = sat32(fN - longint'(imbRef));
        inc = sat32((ex * longint'(dtStep)) >>> DT_FRAC);
        sm  = mInt + inc;
        if (sm > longint'(intLimit)) sm = longint'(intLimit);
        else if (sm < longint'(intFloor)) sm = longint'(intFloor);
        mInt = sm; mFilt = fN;
      end
    end
  end

  task automatic chk(string req, longint act, longint exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkModel(string req);
    chk({req, " integ"}, longint'(integ), mInt);
    chk({req, " alarm"}, longint'(alarm), longint'(lineLoss || (mInt >= longint'(intLimit))));
    chk({req, " trip"}, longint'(trip), longint'(mTrip));
  endtask

  task automatic strobe(input logic signed [15:0] p, input logic signed [15:0] v,
                        input logic signed [15:0] m, input logic [15:0] d);
    @(negedge clk);
    pllErr = p; lineVx = v; lineMag = m; dtStep = d; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  // pllErr, lineVx, lineMag, dtStep
  localparam logic [63:0] VEC [8] = '{
    {16'sd10,  16'sd100,    16'sd100,    16'd16},
    {16'sd40,  16'sd0,      16'sd0,      16'd16},
    {16'sd0,   16'sd300,    16'sd250,    16'd32},
    {-16'sd50, -16'sd20,    16'sd10,     16'd16},
    {16'sd100, 16'sd0,      16'sd0,      16'd8},
    {16'sd0,   16'sd32767,  -16'sd32768, 16'd16},
    {16'sd0,   16'sd0,      16'sd0,      16'd16},
    {16'sd5,   -16'sd7,     -16'sd7,     16'd48}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 0; sampleValid = 0; lineLoss = 0; faultReset = 0;
    pllErr = 0; lineVx = 0; lineMag = 0; dtStep = 16;
    imbRef = 1000; intLimit = 200000; intFloor = -200000;
    filtShift = 1; tripDelay = 200;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10: reset state
    chk("R10 integ", longint'(integ), 0);
    chk("R10 trip", longint'(trip), 0);
    chk("R10 alarm", longint'(alarm), 0);

    // R1 R2 R3 R6: table walk against the reference model
    foreach (VEC[i]) begin
      strobe(VEC[i][63:48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0]);
      chkModel("R1 R2 table");
    end

    // Fresh start for directed cases
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    imbRef = 0; intLimit = 5000; intFloor = -3000; filtShift = 0; tripDelay = 3;
    @(negedge clk);
    chk("R10 integ after reset", longint'(integ), 0);

    // R3 R6: excess 10000 clamps at ceiling, alarm rises
    strobe(16'sd100, 16'sd0, 16'sd0, 16'd16);
    chk("R3 ceiling", longint'(integ), 5000);
    chk("R6 alarm at limit", longint'(alarm), 1);

    // R8: three alarmed strobes needed
    strobe(16'sd100, 16'sd0, 16'sd0, 16'd16);
    strobe(16'sd100, 16'sd0, 16'sd0, 16'd16);
    chk("R8 no trip yet", longint'(trip), 0);
    strobe(16'sd100, 16'sd0, 16'sd0, 16'd16);
    chk("R8 trip set", longint'(trip), 1);

    // R9: fault reset ignored while alarm high
    @(negedge clk); faultReset = 1;
    @(negedge clk); faultReset = 0;
    chk("R9 reset ignored", longint'(trip), 1);

    // R4: large negative excess clamps at floor
    imbRef = 100000;
    strobe(16'sd0, 16'sd0, 16'sd0, 16'd16);
    chk("R4 floor", longint'(integ), -3000);
    chk("R6 alarm low", longint'(alarm), 0);

    // R9: fault reset with alarm low clears trip
    @(negedge clk); faultReset = 1;
    @(negedge clk); faultReset = 0;
    chk("R9 trip cleared", longint'(trip), 0);

    // R5: no strobe, inputs change, integrator holds
    @(negedge clk); imbRef = -100000; pllErr = 16'sd300; dtStep = 16'd200;
    repeat (5) @(negedge clk);
    chk("R5 hold", longint'(integ), -3000);
    imbRef = 100000;

    // R7: line loss forces alarm in the same cycle
    @(negedge clk); lineLoss = 1;
    #1 chk("R7 loss alarm", longint'(alarm), 1);

    // R8: interrupted alarm restarts the count
    strobe(16'sd0, 16'sd0, 16'sd0, 16'd16);
    strobe(16'sd0, 16'sd0, 16'sd0, 16'd16);
    @(negedge clk); lineLoss = 0;
    @(negedge clk); lineLoss = 1;
    strobe(16'sd0, 16'sd0, 16'sd0, 16'd16);
    strobe(16'sd0, 16'sd0, 16'sd0, 16'd16);
    chk("R8 count restarted", longint'(trip), 0);
    strobe(16'sd0, 16'sd0, 16'sd0, 16'd16);
    chk("R8 trip after restart", longint'(trip), 1);
    chkModel("R7 R8 model");
    @(negedge clk); lineLoss = 0;

    done = 1;
    summary();
    $finish;
  end
endmodule